// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the 64-bit effective address of a 32-bit memory-reference instruction from fields that an upstream decoder has already pulled out of the instruction word. Three formats are supported: a long-base format that uses one of the upper general registers, a wide-displacement format anchored on register 16, and a short format. In the short format a 3-bit short-base code selects a base register directly. When that code is zero, the displacement bits switch the block into PC-relative addressing, pointer-indirect array addressing, table-indirect addressing, or one of two auto-increment array modes.

The block reads the 32 x 64-bit general register file through two combinational read ports. For the indirect modes it fetches one 64-bit word through a request/acknowledge memory port. It reports the result with a one-cycle `done` strobe, or with a one-cycle `fault` strobe for an illegal encoding. In the auto-increment modes the block then waits for the host to signal that the data access has completed, and only then writes the advanced index value back through a register-file write port. All address arithmetic wraps modulo 2^64.

Top module: `eaddr_gen`

## Requirements
- R1: With `fmt`=0 (long base), `base_f` values 1..7 select general register 24+`base_f` as the base, and `disp_f[11:0]` is added as an unsigned byte offset. A `base_f` of 0 uses no base register, so the offset alone is the address.
- R2: With `fmt`=1 (wide), the address is register 16 plus `disp_f[14:0]` taken as an unsigned byte offset.
- R3: With `fmt`=2 or 3 (short) and `base_f` nonzero, the address is register 16+`base_f` plus `disp_f[11:0]` taken as an unsigned byte offset.
- R4: In the short format with `base_f`=0 and `disp_f[11]`=0, the address is `insn_end` plus `disp_f[10:0]` sign-extended (range -1024..1023).
- R5: In the short format with `base_f`=0 and `disp_f[11:9]`=100 (array), the block reads memory at register 17 + 8*`disp_f[8:0]`. The effective address is the returned word plus the index value.
- R6: With `disp_f[11:9]`=101 (table), the block reads memory at register 17 + 8*`disp_f[8:0]` + index value. The returned word itself is the effective address.
- R7: With `disp_f[11:9]`=110, the address is formed as in R5. After the access, a nonzero index register is increased by `op_size` (bytes). With an index field of 0, nothing is written.
- R8: With `disp_f[11:9]`=111, the address is formed as in R5. After the access, the index register (2, 4 or 6) is increased by the contents of the register numbered one higher.
- R9: A `disp_f[11:9]`=111 instruction whose index field is odd raises `fault` for one cycle. It issues no memory request and gives no `done`.
- R10: The auto-increment write-back (`rf_we`) happens in the cycle after `access_done` is seen, and never before it.
- R11: An index field of 0 adds nothing. A field of 1..7 adds general register 1..7 in every mode, including direct and PC-relative addressing.
- R12: All sums wrap modulo 2^64.
- R13: After reset `done`, `fault`, `busy`, `mem_req` and `rf_we` are low. `done` and `fault` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation (sampled when idle) |
| fmt | input | 2 | Format: 0 long base, 1 wide, 2/3 short |
| base_f | input | 3 | Base / short-base code |
| disp_f | input | 15 | Raw displacement field |
| idx_f | input | 3 | Index register field |
| op_size | input | 4 | Operand size in bytes |
| insn_end | input | 64 | Address just after the instruction |
| access_done | input | 1 | Host signals the data access completed |
| rf_raddr_a | output | 5 | Register read port A address (base / step) |
| rf_rdata_a | input | 64 | Register read port A data |
| rf_raddr_b | output | 5 | Register read port B address (index) |
| rf_rdata_b | input | 64 | Register read port B data |
| rf_we | output | 1 | Index write-back enable |
| rf_waddr | output | 5 | Index write-back register |
| rf_wdata | output | 64 | Index write-back value |
| mem_req | output | 1 | Indirect fetch request, held until acknowledged |
| mem_addr | output | 64 | Indirect fetch address |
| mem_ack | input | 1 | Fetch acknowledge with valid data |
| mem_rdata | input | 64 | Fetched 64-bit word |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Effective address valid pulse |
| fault | output | 1 | Illegal encoding pulse |
| ea | output | 64 | Effective address |

## Verification
The hardest case to reach from the ports is the gap between the address strobe and the write-back in the auto-increment modes. The block sits waiting on `access_done` while the index register must stay untouched. The bench drives an auto-increment instruction, then holds `access_done` low for several cycles while watching `rf_we` and the modelled register. Only after that does it pulse `access_done` and check the advanced index. The bench also forces the PC-relative sum below zero with an instruction end address of 0, so the wrap shows at the top of the address space.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    K_DIRECT, K_PCREL, K_ARRAY, K_TABLE, K_AINC, K_FLEX
  } ea_kind_e;

  typedef enum logic [1:0] {
    S_IDLE, S_CALC, S_FETCH, S_WAITACC
  } eag_state_e;
endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int DW   = 15
) (
  input  logic [1:0]      fmt,
  input  logic [2:0]      base_f,
  input  logic [DW-1:0]   disp_f,
  input  logic [2:0]      idx_f,
  output ea_kind_e        kind,
  output logic            base_en,
  output logic [4:0]      base_sel,
  output logic [XLEN-1:0] offset,
  output logic            illegal
);
  localparam int SHORTW = 12;
  localparam int RELW   = 11;
  localparam int SCW    = 9;

  always_comb begin
    kind     = K_DIRECT;
    base_en  = 1'b0;
    base_sel = 5'd0;
    offset   = '0;
    illegal  = 1'b0;
    case (fmt)
      2'd0: begin
        base_en  = (base_f != 3'd0);
        base_sel = {2'b11, base_f};
        offset   = {{(XLEN-SHORTW){1'b0}}, disp_f[SHORTW-1:0]};
      end
      2'd1: begin
        base_en  = 1'b1;
        base_sel = 5'd16;
        offset   = {{(XLEN-DW){1'b0}}, disp_f};
      end
      default: begin
        if (base_f != 3'd0) begin
          base_en  = 1'b1;
          base_sel = {2'b10, base_f};
          offset   = {{(XLEN-SHORTW){1'b0}}, disp_f[SHORTW-1:0]};
        end else if (!disp_f[SHORTW-1]) begin
          kind   = K_PCREL;
          offset = {{(XLEN-RELW){disp_f[RELW-1]}}, disp_f[RELW-1:0]};
        end else begin
          base_en  = 1'b1;
          base_sel = 5'd17;
          offset   = {{(XLEN-SCW-3){1'b0}}, disp_f[SCW-1:0], 3'b000};
          case (disp_f[10:9])
            2'b00:   kind = K_ARRAY;
            2'b01:   kind = K_TABLE;
            2'b10:   kind = K_AINC;
            default: kind = K_FLEX;
          endcase
          illegal = (disp_f[10:9] == 2'b11) && idx_f[0];
        end
      end
    endcase
  end
endmodule

// File: rtl/eag_incr.sv
module eag_incr
  import eag_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SW   = 4
) (
  input  ea_kind_e        kind,
  input  logic [SW-1:0]   op_size,
  input  logic [XLEN-1:0] step_reg,
  input  logic [XLEN-1:0] idx_val,
  output logic [XLEN-1:0] idx_next
);
  logic [XLEN-1:0] step;

  always_comb begin
    if (kind == K_FLEX) step = step_reg;
    else                step = {{(XLEN-SW){1'b0}}, op_size};
    idx_next = idx_val + step;
  end
endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen
  import eag_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int DW   = 15,
  parameter int SW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      fmt,
  input  logic [2:0]      base_f,
  input  logic [DW-1:0]   disp_f,
  input  logic [2:0]      idx_f,
  input  logic [SW-1:0]   op_size,
  input  logic [XLEN-1:0] insn_end,
  input  logic            access_done,
  output logic [4:0]      rf_raddr_a,
  input  logic [XLEN-1:0] rf_rdata_a,
  output logic [4:0]      rf_raddr_b,
  input  logic [XLEN-1:0] rf_rdata_b,
  output logic            rf_we,
  output logic [4:0]      rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [XLEN-1:0] ea
);
  ea_kind_e        d_kind, q_kind;
  logic            d_base_en, q_base_en;
  logic [4:0]      d_base_sel, q_base_sel;
  logic [XLEN-1:0] d_offset, q_offset;
  logic            d_illegal, q_illegal;
  logic [2:0]      q_idx_f;
  logic [SW-1:0]   q_size;
  logic [XLEN-1:0] q_end;

  eag_state_e      state, n_state;
  logic            n_done, n_fault, n_req, n_we;
  logic [XLEN-1:0] n_ea, n_maddr, n_wdata, n_idxv, idxv_q;
  logic [4:0]      n_waddr;

  logic [XLEN-1:0] base_v, idx_val, anchor, sum, idx_next;
  logic            load;
  logic            auto_mode;

  eag_decode #(.XLEN(XLEN), .DW(DW)) u_dec (
    .fmt(fmt), .base_f(base_f), .disp_f(disp_f), .idx_f(idx_f),
    .kind(d_kind), .base_en(d_base_en), .base_sel(d_base_sel),
    .offset(d_offset), .illegal(d_illegal)
  );

  eag_incr #(.XLEN(XLEN), .SW(SW)) u_inc (
    .kind(q_kind), .op_size(q_size), .step_reg(rf_rdata_a),
    .idx_val(idx_val), .idx_next(idx_next)
  );

  assign load       = (state == S_IDLE) && start;
  assign busy       = (state != S_IDLE);
  assign auto_mode  = (q_kind == K_AINC) || (q_kind == K_FLEX);
  assign rf_raddr_a = (state == S_WAITACC) ? ({2'b00, q_idx_f} + 5'd1) : q_base_sel;
  assign rf_raddr_b = {2'b00, q_idx_f};

  always_comb begin
    base_v  = q_base_en ? rf_rdata_a : '0;
    idx_val = (q_idx_f != 3'd0) ? rf_rdata_b : '0;
    anchor  = (q_kind == K_PCREL) ? q_end : base_v;
    sum     = anchor + q_offset;
  end

  // next-state and next-output logic
  always_comb begin
    n_state = state;
    n_done  = 1'b0;
    n_fault = 1'b0;
    n_we    = 1'b0;
    n_req   = mem_req;
    n_maddr = mem_addr;
    n_ea    = ea;
    n_waddr = rf_waddr;
    n_wdata = rf_wdata;
    n_idxv  = idxv_q;
    case (state)
      S_IDLE: if (start) n_state = S_CALC;
      S_CALC: begin
        if (q_illegal) begin
          n_fault = 1'b1;
          n_state = S_IDLE;
        end else if ((q_kind == K_DIRECT) || (q_kind == K_PCREL)) begin
          n_ea    = sum + idx_val;
          n_done  = 1'b1;
          n_state = S_IDLE;
        end else begin
          n_maddr = (q_kind == K_TABLE) ? (sum + idx_val) : sum;
          n_req   = 1'b1;
          n_idxv  = idx_val;
          n_state = S_FETCH;
        end
      end
      S_FETCH: if (mem_ack) begin
        n_req   = 1'b0;
        n_ea    = (q_kind == K_TABLE) ? mem_rdata : (mem_rdata + idxv_q);
        n_done  = 1'b1;
        n_state = (auto_mode && (q_idx_f != 3'd0)) ? S_WAITACC : S_IDLE;
      end
      S_WAITACC: if (access_done) begin
        n_we    = 1'b1;
        n_waddr = {2'b00, q_idx_f};
        n_wdata = idx_next;
        n_state = S_IDLE;
      end
      default: n_state = S_IDLE;
    endcase
  end

  // instruction field capture, enabled on start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_kind     <= K_DIRECT;
      q_base_en  <= 1'b0;
      q_base_sel <= 5'd0;
      q_offset   <= '0;
      q_illegal  <= 1'b0;
      q_idx_f    <= 3'd0;
      q_size     <= '0;
      q_end      <= '0;
    end else if (load) begin
      q_kind     <= d_kind;
      q_base_en  <= d_base_en;
      q_base_sel <= d_base_sel;
      q_offset   <= d_offset;
      q_illegal  <= d_illegal;
      q_idx_f    <= idx_f;
      q_size     <= op_size;
      q_end      <= insn_end;
    end
  end

  // state and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      fault    <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      ea       <= '0;
      rf_we    <= 1'b0;
      rf_waddr <= 5'd0;
      rf_wdata <= '0;
      idxv_q   <= '0;
    end else begin
      state    <= n_state;
      done     <= n_done;
      fault    <= n_fault;
      mem_req  <= n_req;
      mem_addr <= n_maddr;
      ea       <= n_ea;
      rf_we    <= n_we;
      rf_waddr <= n_waddr;
      rf_wdata <= n_wdata;
      idxv_q   <= n_idxv;
    end
  end
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done,
  input logic            fault,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [XLEN-1:0] mem_addr,
  input logic            rf_we,
  input logic [4:0]      rf_waddr,
  input logic            access_done
);
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  p_fault_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!done && !mem_req));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_wb_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_we) |-> $past(access_done));

  p_wb_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ((rf_waddr != 5'd0) && (rf_waddr < 5'd8)));
endmodule

bind eaddr_gen eag_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .fault(fault),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .rf_we(rf_we), .rf_waddr(rf_waddr), .access_done(access_done)
);

// File: tb/tb_eaddr_gen.sv
module tb_eaddr_gen;
  localparam logic [63:0] MEMOFS = 64'h0000_0100_0000_0000;
  localparam logic [63:0] PCE    = 64'h5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, access_done, mem_ack;
  logic [1:0]  fmt;
  logic [2:0]  base_f, idx_f;
  logic [14:0] disp_f;
  logic [3:0]  op_size;
  logic [63:0] insn_end, mem_rdata, rf_rdata_a, rf_rdata_b;
  logic [4:0]  rf_raddr_a, rf_raddr_b, rf_waddr;
  logic        rf_we, mem_req, busy, done, fault;
  logic [63:0] rf_wdata, mem_addr, ea;
  logic [63:0] rf [32];
  int          checks = 0, fails = 0, we_seen = 0;

  always #5 clk = ~clk;

  assign rf_rdata_a = rf[rf_raddr_a];
  assign rf_rdata_b = rf[rf_raddr_b];

  eaddr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .base_f(base_f),
    .disp_f(disp_f), .idx_f(idx_f), .op_size(op_size), .insn_end(insn_end),
    .access_done(access_done), .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a),
    .rf_raddr_b(rf_raddr_b), .rf_rdata_b(rf_rdata_b), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fault(fault), .ea(ea)
  );

  typedef struct packed {
    logic [1:0]  fm;
    logic [2:0]  bf;
    logic [14:0] df;
    logic [2:0]  ix;
    logic [3:0]  sz;
    logic [63:0] exp_ea;
    logic        exp_flt;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd1, 15'h0123, 3'd0, 4'd8, 64'h0000_0000_0001_9123, 1'b0}, // R1
    '{2'd0, 3'd7, 15'h0010, 3'd3, 4'd8, 64'h0000_0000_0002_2010, 1'b0}, // R1 R11
    '{2'd0, 3'd0, 15'h0456, 3'd0, 4'd8, 64'h0000_0000_0000_0456, 1'b0}, // R1
    '{2'd1, 3'd0, 15'h7FFF, 3'd0, 4'd8, 64'h0000_0000_0001_7FFF, 1'b0}, // R2
    '{2'd2, 3'd1, 15'h0FFF, 3'd0, 4'd8, 64'h0000_0000_0001_1FFF, 1'b0}, // R3
    '{2'd3, 3'd7, 15'h0800, 3'd2, 4'd8, 64'h0000_0000_0001_9800, 1'b0}, // R3 R11
    '{2'd2, 3'd0, 15'h03FF, 3'd0, 4'd8, 64'h0000_0000_0000_53FF, 1'b0}, // R4
    '{2'd2, 3'd0, 15'h0400, 3'd0, 4'd8, 64'h0000_0000_0000_4C00, 1'b0}, // R4
    '{2'd2, 3'd0, 15'h0010, 3'd1, 4'd8, 64'h0000_0000_0000_6010, 1'b0}, // R4 R11
    '{2'd2, 3'd0, 15'h0805, 3'd1, 4'd8, 64'h0000_0100_0001_2028, 1'b0}, // R5
    '{2'd2, 3'd0, 15'h09FF, 3'd0, 4'd8, 64'h0000_0100_0001_1FF8, 1'b0}, // R5
    '{2'd2, 3'd0, 15'h0A02, 3'd4, 4'd8, 64'h0000_0100_0001_5010, 1'b0}, // R6
    '{2'd2, 3'd0, 15'h0A00, 3'd0, 4'd8, 64'h0000_0100_0001_1000, 1'b0}, // R6
    '{2'd2, 3'd0, 15'h0E00, 3'd3, 4'd8, 64'h0000_0000_0000_0000, 1'b1}  // R9
  };

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // memory responder and register-file model, updated away from the active edge
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack   = 1'b1;
        mem_rdata = mem_addr + MEMOFS;
      end else begin
        mem_ack = 1'b0;
      end
      if (rf_we) begin
        rf[rf_waddr] = rf_wdata;
        we_seen++;
      end
    end
  end

  task automatic run(input vec_t v, input logic [63:0] iend,
                     output logic [63:0] ea_o, output logic flt_o);
    @(negedge clk);
    fmt = v.fm; base_f = v.bf; disp_f = v.df; idx_f = v.ix;
    op_size = v.sz; insn_end = iend; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ea_o = 'x; flt_o = 1'b0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (done || fault) begin
        ea_o = ea; flt_o = fault;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R13 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] got;
    logic        gflt;
    int          we0;
    vec_t        v;
    for (int i = 0; i < 32; i++) rf[i] = 64'(i) << 12;
    rst_n = 1'b0; start = 1'b0; access_done = 1'b0;
    fmt = '0; base_f = '0; disp_f = '0; idx_f = '0; op_size = '0; insn_end = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(!done && !fault && !busy && !mem_req && !rf_we, "R13 reset",
          {59'd0, done, fault, busy, mem_req, rf_we}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i], PCE, got, gflt);
      check(gflt == VECS[i].exp_flt, $sformatf("R9 fault flag vec%0d", i),
            {63'd0, gflt}, {63'd0, VECS[i].exp_flt});
      if (!VECS[i].exp_flt)
        check(got == VECS[i].exp_ea, $sformatf("R1-6 ea vec%0d", i), got, VECS[i].exp_ea);
    end
    check(we_seen == 0, "R7 no write-back from non-increment modes",
          64'(we_seen), 64'd0);

    // R12 wrap: PC-relative -4 from address 0
    v = '{2'd2, 3'd0, 15'h07FC, 3'd0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0};
    run(v, 64'd0, got, gflt);
    check(got == v.exp_ea && !gflt, "R12 wrap", got, v.exp_ea);

    // R7 R10 auto-increment by operand size 6 on register 5
    v = '{2'd2, 3'd0, 15'h0C03, 3'd5, 4'd6, 64'h0000_0100_0001_6018, 1'b0};
    run(v, PCE, got, gflt);
    check(got == v.exp_ea && !gflt, "R7 ea", got, v.exp_ea);
    we0 = we_seen;
    repeat (4) @(negedge clk);
    check(we_seen == we0 && rf[5] == 64'h5000, "R10 no write before access_done",
          rf[5], 64'h5000);
    check(busy, "R10 waits for access_done", {63'd0, busy}, 64'd1);
    access_done = 1'b1;
    @(negedge clk);
    access_done = 1'b0;
    @(negedge clk);
    check(rf[5] == 64'h5006, "R7 index advanced by size", rf[5], 64'h5006);
    check(!busy, "R10 returns idle", {63'd0, busy}, 64'd0);

    // R7 auto-increment with no index: no write-back
    v = '{2'd2, 3'd0, 15'h0C00, 3'd0, 4'd4, 64'h0000_0100_0001_1000, 1'b0};
    we0 = we_seen;
    run(v, PCE, got, gflt);
    check(got == v.exp_ea, "R7 unindexed ea", got, v.exp_ea);
    repeat (3) @(negedge clk);
    check(we_seen == we0 && !busy, "R7 unindexed no write", 64'(we_seen - we0), 64'd0);

    // R8 flexible increment: register 2 advanced by register 3
    v = '{2'd2, 3'd0, 15'h0E01, 3'd2, 4'd1, 64'h0000_0100_0001_3008, 1'b0};
    run(v, PCE, got, gflt);
    check(got == v.exp_ea && !gflt, "R8 ea", got, v.exp_ea);
    access_done = 1'b1;
    @(negedge clk);
    access_done = 1'b0;
    @(negedge clk);
    check(rf[2] == 64'h5000, "R8 index advanced by next register", rf[2], 64'h5000);

    // R9 illegal leaves registers alone and issues no request
    v = '{2'd2, 3'd0, 15'h0E00, 3'd7, 4'd1, 64'd0, 1'b1};
    run(v, PCE, got, gflt);
    check(gflt && !mem_req, "R9 illegal index 7", {63'd0, gflt}, 64'd1);
    check(rf[7] == 64'h7000, "R9 no register change", rf[7], 64'h7000);

    finish_run();
  end
endmodule